// File: doc/BRIEF.md
# DRAM Page Access Classifier

This block watches the decoded command stream of one DRAM channel and sorts every row access into one of three outcomes, per bank. A read or write to a row that has already been touched since it was opened is a hit. The first read or write after the row was opened is a miss, because an activate had to be spent on it. A row that is opened and then closed without any read or write is unused: both the time and the power spent opening it were wasted. The block keeps, for each bank, whether a row is open, which row it is, and whether that row has been accessed since it was activated.

Hits and misses are counted separately for reads and for writes. Unused rows carry no direction. Every count is kept per bank, and the bank index includes the rank, so the counts split by rank and by bank. One instance serves one channel. Counts stop at their maximum value instead of wrapping. A synchronous clear input empties all counters and closes every bank. Software reads each counter, and a state word for each bank, through a plain address/data read port with one cycle of latency.

Top module: `page_hit_classifier`

## Requirements
- R1: While `rst_n` is low, and in the cycle after `clr` was high, every counter reads zero and every bank reads closed. A cycle with `clr` high produces no counting events.
- R2: A command with `cmd_valid` high and `cmd_op` = 1 (activate) opens the addressed bank, stores `cmd_row` and marks the bank as not yet accessed. The state word has bit DATA_W-1 = open, bit DATA_W-2 = accessed, and the row in the low ROW_W bits.
- R3: The first read (`cmd_op` 2 or 4) or write (`cmd_op` 3 or 5) to an open bank after its activate adds one to that bank's read-miss or write-miss counter, and sets the accessed flag. At most one bank records an access in any cycle.
- R4: A read or write to an open bank whose accessed flag is already set adds one to that bank's read-hit or write-hit counter.
- R5: A single-bank precharge (`cmd_op` = 6) closes the addressed bank. If the bank was open and never accessed, the bank's unused counter goes up by one. A precharge to a closed bank has no effect.
- R6: A precharge-all (`cmd_op` = 7) closes every bank of `cmd_rank`. Each bank that was open and never accessed adds one to its own unused counter. Banks of the other ranks do not change.
- R7: A read or write with auto-precharge (`cmd_op` 4 or 5) is first classified as a hit or a miss, and then leaves the bank closed.
- R8: An activate to a bank that is already open first closes the old row, counting it as unused if it was never accessed, and then opens the new row.
- R9: A read or write to a closed bank, `cmd_op` = 0 (refresh, mode-register and other commands), and any command with `cmd_valid` low change no counter and no bank state.
- R10: A counter that has reached 2^CNT_W-1 stays at that value when further events arrive.
- R11: Read address = bank index × 8 + selector, where bank index = {rank, bank group, bank}. Selectors: 0 read-hit, 1 read-miss, 2 write-hit, 3 write-miss, 4 unused, 5 state word, 6 and 7 read zero. `rd_data` shows the value that was present at the clock edge where the address was sampled, and appears one cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of all counters and bank state |
| cmd_valid | input | 1 | A decoded command is present this cycle |
| cmd_op | input | 3 | Command code: 0 other, 1 activate, 2 read, 3 write, 4 read+AP, 5 write+AP, 6 precharge, 7 precharge-all |
| cmd_rank | input | RANK_W | Target rank |
| cmd_bg | input | BG_W | Target bank group |
| cmd_ba | input | BA_W | Target bank within the group |
| cmd_row | input | ROW_W | Row address (used on activate) |
| rd_addr | input | IDX_W+3 | Read address: bank index and selector |
| rd_data | output | DATA_W | Registered read data |

## Verification
A command sampled at clock edge N updates the bank state and counters at that same edge. A read address presented in the next cycle is registered at edge N+1. Its data is therefore valid after edge N+1, two edges after the command. The bench drives every input at the falling edge. It issues the read address in the cycle after the command and compares `rd_data` at the following falling edge, which always falls inside this two-edge window. Precharge-all and auto-precharge outcomes are read back the same way, through the counters and the state word of every bank they could have touched.

// File: rtl/phc_pkg.sv
package phc_pkg;

   typedef enum logic [2:0] {
      OP_OTHER = 3'd0,
      OP_ACT   = 3'd1,
      OP_RD    = 3'd2,
      OP_WR    = 3'd3,
      OP_RDA   = 3'd4,
      OP_WRA   = 3'd5,
      OP_PRE   = 3'd6,
      OP_PREA  = 3'd7
   } phc_op_e;

   localparam int NKIND     = 5;
   localparam int K_RD_HIT  = 0;
   localparam int K_RD_MISS = 1;
   localparam int K_WR_HIT  = 2;
   localparam int K_WR_MISS = 3;
   localparam int K_UNUSED  = 4;
   localparam int SEL_STATE = 5;
   localparam int SEL_W     = 3;

endpackage

// File: rtl/phc_sat_cnt.sv
module phc_sat_cnt #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] q
);
   localparam logic [W-1:0] TOP = {W{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= '0;
      else if (clr)
         q <= '0;
      else if (inc && (q != TOP))
         q <= q + 1'b1;
   end
endmodule

// File: rtl/phc_bank_state.sv
module phc_bank_state
   import phc_pkg::*;
#(
   parameter int ROW_W = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             bank_sel,
   input  logic             rank_sel,
   input  phc_op_e          op,
   input  logic [ROW_W-1:0] row_in,
   output logic [NKIND-1:0] ev,
   output logic             is_open,
   output logic             was_used,
   output logic [ROW_W-1:0] open_row
);
   logic is_act, is_rd, is_wr, is_auto, access, close_req;

   always_comb begin
      is_act    = bank_sel && (op == OP_ACT);
      is_rd     = (op == OP_RD) || (op == OP_RDA);
      is_wr     = (op == OP_WR) || (op == OP_WRA);
      is_auto   = (op == OP_RDA) || (op == OP_WRA);
      access    = bank_sel && is_open && (is_rd || is_wr);
      close_req = is_act
                  || (bank_sel && (op == OP_PRE))
                  || (rank_sel && (op == OP_PREA));
   end

   always_comb begin
      ev = '0;
      if (!clr) begin
         ev[K_RD_HIT]  = access && is_rd && was_used;
         ev[K_RD_MISS] = access && is_rd && !was_used;
         ev[K_WR_HIT]  = access && is_wr && was_used;
         ev[K_WR_MISS] = access && is_wr && !was_used;
         ev[K_UNUSED]  = close_req && is_open && !was_used;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         is_open  <= 1'b0;
         was_used <= 1'b0;
         open_row <= '0;
      end else if (clr) begin
         is_open  <= 1'b0;
         was_used <= 1'b0;
         open_row <= '0;
      end else if (is_act) begin
         is_open  <= 1'b1;
         was_used <= 1'b0;
         open_row <= row_in;
      end else if (access) begin
         was_used <= 1'b1;
         if (is_auto)
            is_open <= 1'b0;
      end else if (close_req) begin
         is_open <= 1'b0;
      end
   end
endmodule

// File: rtl/page_hit_classifier.sv
module page_hit_classifier
   import phc_pkg::*;
#(
   parameter int RANK_W = 1,
   parameter int BG_W   = 1,
   parameter int BA_W   = 2,
   parameter int ROW_W  = 14,
   parameter int CNT_W  = 16,
   localparam int IDX_W  = RANK_W + BG_W + BA_W,
   localparam int AW     = IDX_W + SEL_W,
   localparam int DATA_W = (CNT_W > ROW_W + 2) ? CNT_W : ROW_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              cmd_valid,
   input  logic [2:0]        cmd_op,
   input  logic [RANK_W-1:0] cmd_rank,
   input  logic [BG_W-1:0]   cmd_bg,
   input  logic [BA_W-1:0]   cmd_ba,
   input  logic [ROW_W-1:0]  cmd_row,
   input  logic [AW-1:0]     rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   localparam int NB    = 1 << IDX_W;
   localparam int BPR_W = BG_W + BA_W;

   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt
      $error("CNT_W must lie in 2..32");
   end
   if (ROW_W < 1 || ROW_W > 30) begin : g_bad_row
      $error("ROW_W must lie in 1..30");
   end
   if (IDX_W > 8) begin : g_bad_idx
      $error("too many banks for one instance");
   end

   phc_op_e                              eff_op;
   logic [IDX_W-1:0]                     cmd_idx;
   logic [NB-1:0][NKIND-1:0]             ev;
   logic [NB-1:0]                        bank_open;
   logic [NB-1:0]                        bank_used;
   logic [NB-1:0][ROW_W-1:0]             bank_row;
   logic [NKIND-1:0][NB-1:0][CNT_W-1:0]  cnt_q;

   always_comb begin
      eff_op  = cmd_valid ? phc_op_e'(cmd_op) : OP_OTHER;
      cmd_idx = {cmd_rank, cmd_bg, cmd_ba};
   end

   for (genvar b = 0; b < NB; b++) begin : g_bank
      localparam logic [IDX_W-1:0]  BIDX  = IDX_W'(b);
      localparam logic [RANK_W-1:0] BRANK = RANK_W'(b >> BPR_W);
      logic bsel, rsel;
      assign bsel = (cmd_idx == BIDX);
      assign rsel = (cmd_rank == BRANK);

      phc_bank_state #(.ROW_W(ROW_W)) u_state (
         .clk      (clk),
         .rst_n    (rst_n),
         .clr      (clr),
         .bank_sel (bsel),
         .rank_sel (rsel),
         .op       (eff_op),
         .row_in   (cmd_row),
         .ev       (ev[b]),
         .is_open  (bank_open[b]),
         .was_used (bank_used[b]),
         .open_row (bank_row[b])
      );

      for (genvar k = 0; k < NKIND; k++) begin : g_kind
         phc_sat_cnt #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr),
            .inc   (ev[b][k]),
            .q     (cnt_q[k][b])
         );
      end
   end

   logic [IDX_W-1:0]  rd_bank;
   logic [SEL_W-1:0]  rd_sel;
   logic [DATA_W-1:0] state_word;
   logic [DATA_W-1:0] mux_d;

   always_comb begin
      rd_bank    = rd_addr[AW-1:SEL_W];
      rd_sel     = rd_addr[SEL_W-1:0];
      state_word = '0;
      state_word[DATA_W-1]  = bank_open[rd_bank];
      state_word[DATA_W-2]  = bank_used[rd_bank];
      state_word[ROW_W-1:0] = bank_row[rd_bank];
      case (rd_sel)
         SEL_W'(K_RD_HIT):  mux_d = DATA_W'(cnt_q[K_RD_HIT][rd_bank]);
         SEL_W'(K_RD_MISS): mux_d = DATA_W'(cnt_q[K_RD_MISS][rd_bank]);
         SEL_W'(K_WR_HIT):  mux_d = DATA_W'(cnt_q[K_WR_HIT][rd_bank]);
         SEL_W'(K_WR_MISS): mux_d = DATA_W'(cnt_q[K_WR_MISS][rd_bank]);
         SEL_W'(K_UNUSED):  mux_d = DATA_W'(cnt_q[K_UNUSED][rd_bank]);
         SEL_W'(SEL_STATE): mux_d = state_word;
         default:           mux_d = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rd_data <= '0;
      else
         rd_data <= mux_d;
   end
endmodule

// File: rtl/phc_checker.sv
module phc_checker
   import phc_pkg::*;
#(
   parameter int RANK_W = 1,
   parameter int BG_W   = 1,
   parameter int BA_W   = 2,
   parameter int CNT_W  = 16
) (
   input logic                                                   clk,
   input logic                                                   rst_n,
   input logic                                                   clr,
   input logic                                                   cmd_valid,
   input logic [2:0]                                             cmd_op,
   input logic [RANK_W-1:0]                                      cmd_rank,
   input logic [BG_W-1:0]                                        cmd_bg,
   input logic [BA_W-1:0]                                        cmd_ba,
   input logic [(1<<(RANK_W+BG_W+BA_W))-1:0]                     bank_open,
   input logic [(1<<(RANK_W+BG_W+BA_W))-1:0][NKIND-1:0]          ev,
   input logic [NKIND-1:0][(1<<(RANK_W+BG_W+BA_W))-1:0][CNT_W-1:0] cnt_q
);
   localparam int IDX_W = RANK_W + BG_W + BA_W;
   localparam int NB    = 1 << IDX_W;
   localparam int BPR   = 1 << (BG_W + BA_W);
   localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

   logic [IDX_W-1:0]  cur_idx, prev_idx;
   logic [RANK_W-1:0] prev_rank;
   logic [NB-1:0]     acc_vec;
   logic              any_ev;
   logic [BPR-1:0]    rank_open;
   logic              is_access;

   always_comb begin
      cur_idx = {cmd_rank, cmd_bg, cmd_ba};
      any_ev  = 1'b0;
      for (int b = 0; b < NB; b++) begin
         acc_vec[b] = |ev[b][K_WR_MISS:K_RD_HIT];
         any_ev     = any_ev | (|ev[b]);
      end
      rank_open = bank_open[prev_rank*BPR +: BPR];
      is_access = (cmd_op == OP_RD) || (cmd_op == OP_WR)
                  || (cmd_op == OP_RDA) || (cmd_op == OP_WRA);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_idx  <= '0;
         prev_rank <= '0;
      end else begin
         prev_idx  <= cur_idx;
         prev_rank <= cmd_rank;
      end
   end

   AST_CLEAR_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (bank_open == '0)); // R1
   AST_CLEAR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      clr |-> !any_ev); // R1
   AST_ACT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == OP_ACT && !clr) |=> bank_open[prev_idx]); // R2
   AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(acc_vec) <= 1); // R3
   AST_PREA_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == OP_PREA && !clr) |=> (rank_open == '0)); // R6
   AST_AUTO_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && (cmd_op == OP_RDA || cmd_op == OP_WRA) && !clr)
      |=> !bank_open[prev_idx]); // R7
   AST_CLOSED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && is_access && !bank_open[cur_idx]) |-> (acc_vec == '0)); // R9

   for (genvar k = 0; k < NKIND; k++) begin : g_sat
      AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         (cnt_q[k][0] == TOP && !clr) |=> (cnt_q[k][0] == TOP)); // R10
   end
endmodule

bind page_hit_classifier phc_checker #(
   .RANK_W (RANK_W),
   .BG_W   (BG_W),
   .BA_W   (BA_W),
   .CNT_W  (CNT_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .clr       (clr),
   .cmd_valid (cmd_valid),
   .cmd_op    (cmd_op),
   .cmd_rank  (cmd_rank),
   .cmd_bg    (cmd_bg),
   .cmd_ba    (cmd_ba),
   .bank_open (bank_open),
   .ev        (ev),
   .cnt_q     (cnt_q)
);

// File: tb/sim_page_hit_classifier.sv
`timescale 1ns/1ps
module sim_page_hit_classifier;
   localparam int RANK_W = 1;
   localparam int BG_W   = 1;
   localparam int BA_W   = 2;
   localparam int ROW_W  = 14;
   localparam int CNT_W  = 4;
   localparam int IDX_W  = RANK_W + BG_W + BA_W;
   localparam int NB     = 1 << IDX_W;
   localparam int BPR    = 1 << (BG_W + BA_W);
   localparam int AW     = IDX_W + 3;
   localparam int DW     = (CNT_W > ROW_W + 2) ? CNT_W : ROW_W + 2;
   localparam int MAXC   = (1 << CNT_W) - 1;

   localparam int ACT = 1, RD = 2, WR = 3, RDA = 4, WRA = 5, PRE = 6, PREA = 7;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              clr = 1'b0;
   logic              cmd_valid = 1'b0;
   logic [2:0]        cmd_op = '0;
   logic [RANK_W-1:0] cmd_rank = '0;
   logic [BG_W-1:0]   cmd_bg = '0;
   logic [BA_W-1:0]   cmd_ba = '0;
   logic [ROW_W-1:0]  cmd_row = '0;
   logic [AW-1:0]     rd_addr = '0;
   logic [DW-1:0]     rd_data;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   page_hit_classifier #(
      .RANK_W(RANK_W), .BG_W(BG_W), .BA_W(BA_W), .ROW_W(ROW_W), .CNT_W(CNT_W)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .clr(clr), .cmd_valid(cmd_valid),
      .cmd_op(cmd_op), .cmd_rank(cmd_rank), .cmd_bg(cmd_bg), .cmd_ba(cmd_ba),
      .cmd_row(cmd_row), .rd_addr(rd_addr), .rd_data(rd_data)
   );

   // reference model
   bit             m_open [NB];
   bit             m_used [NB];
   int             m_row  [NB];
   int             m_cnt  [NB][5];

   function automatic int sat_inc(input int v);
      return (v >= MAXC) ? MAXC : v + 1;
   endfunction

   function automatic void model_clear();
      for (int b = 0; b < NB; b++) begin
         m_open[b] = 0; m_used[b] = 0; m_row[b] = 0;
         for (int k = 0; k < 5; k++) m_cnt[b][k] = 0;
      end
   endfunction

   function automatic void model_close(input int b);
      if (m_open[b] && !m_used[b]) m_cnt[b][4] = sat_inc(m_cnt[b][4]);
      m_open[b] = 0;
   endfunction

   function automatic void model_apply(input int op, input int b, input int row);
      case (op)
         ACT: begin
            model_close(b);
            m_open[b] = 1; m_used[b] = 0; m_row[b] = row;
         end
         RD, WR, RDA, WRA: if (m_open[b]) begin
            int k;
            k = ((op == WR || op == WRA) ? 2 : 0) + (m_used[b] ? 0 : 1);
            m_cnt[b][k] = sat_inc(m_cnt[b][k]);
            m_used[b] = 1;
            if (op == RDA || op == WRA) m_open[b] = 0;
         end
         PRE: model_close(b);
         PREA: begin
            int r;
            r = b / BPR;
            for (int i = r * BPR; i < (r + 1) * BPR; i++) model_close(i);
         end
         default: ;
      endcase
   endfunction

   function automatic int model_reg(input int b, input int s);
      if (s < 5) return m_cnt[b][s];
      if (s == 5) return (int'(m_open[b]) << (DW - 1)) | (int'(m_used[b]) << (DW - 2)) | m_row[b];
      return 0;
   endfunction

   task automatic issue(input int op, input int b, input int row);
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd_op    = 3'(op);
      {cmd_rank, cmd_bg, cmd_ba} = IDX_W'(b);
      cmd_row   = ROW_W'(row);
      @(posedge clk);
      model_apply(op, b, row);
   endtask

   task automatic do_clear();
      @(negedge clk);
      cmd_valid = 1'b0;
      clr = 1'b1;
      @(posedge clk);
      model_clear();
      @(negedge clk);
      clr = 1'b0;
   endtask

   task automatic chk_reg(input int b, input int s, input string req);
      int exp;
      @(negedge clk);
      cmd_valid = 1'b0;
      rd_addr   = AW'(b * 8 + s);
      @(posedge clk);
      @(negedge clk);
      exp = model_reg(b, s);
      checks++;
      if (rd_data !== DW'(exp)) begin
         fails++;
         $display("FAIL %s bank %0d sel %0d: actual %0h expected %0h", req, b, s, rd_data, exp);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      model_clear();
      repeat (3) @(posedge clk);
      // R1: reset state, checked while reset still low
      @(negedge clk);
      rd_addr = AW'(5);
      @(posedge clk);
      @(negedge clk);
      checks++;
      if (rd_data !== '0) begin
         fails++;
         $display("FAIL R1 reset state: actual %0h expected 0", rd_data);
      end
      rst_n = 1'b1;
      chk_reg(0, 4, "R1");

      // R2: activate opens and records row
      issue(ACT, 3, 14'h123);
      chk_reg(3, 5, "R2");
      // R3 then R4
      issue(RD, 3, 0);
      chk_reg(3, 1, "R3");
      issue(RD, 3, 0);
      chk_reg(3, 0, "R4");
      issue(WR, 3, 0);
      chk_reg(3, 2, "R4");
      chk_reg(3, 3, "R3");
      // R5: precharge of accessed bank, then unused case
      issue(PRE, 3, 0);
      chk_reg(3, 4, "R5");
      chk_reg(3, 5, "R5");
      issue(ACT, 5, 14'h0AA);
      issue(PRE, 5, 0);
      chk_reg(5, 4, "R5");
      issue(PRE, 5, 0);
      chk_reg(5, 4, "R5");
      // R9: access to closed bank and op 0 ignored
      issue(RD, 5, 0);
      chk_reg(5, 1, "R9");
      issue(0, 5, 14'h3FF);
      chk_reg(5, 5, "R9");
      // R6: precharge-all on rank 1 leaves rank 0 open
      issue(ACT, 9, 14'h011);
      issue(ACT, 10, 14'h022);
      issue(WR, 10, 0);
      issue(ACT, 2, 14'h033);
      issue(PREA, 8, 0);
      chk_reg(9, 4, "R6");
      chk_reg(10, 4, "R6");
      chk_reg(10, 5, "R6");
      chk_reg(2, 5, "R6");
      // R7: write with auto-precharge is a miss then closes
      issue(WRA, 2, 0);
      chk_reg(2, 3, "R7");
      chk_reg(2, 5, "R7");
      // R8: activate over an untouched open row
      issue(ACT, 4, 14'h100);
      issue(ACT, 4, 14'h200);
      chk_reg(4, 4, "R8");
      chk_reg(4, 5, "R8");
      // R10: saturation of unused counter of bank 0
      for (int i = 0; i < MAXC + 4; i++) begin
         issue(ACT, 0, i);
         issue(PRE, 0, 0);
      end
      chk_reg(0, 4, "R10");
      // R11: unmapped selectors read zero
      chk_reg(0, 6, "R11");
      chk_reg(3, 7, "R11");
      // R1: clear
      do_clear();
      chk_reg(0, 4, "R1");
      chk_reg(3, 5, "R1");

      // random phase
      for (int i = 0; i < 600; i++) begin
         int op, b;
         op = $urandom_range(0, 7);
         b  = $urandom_range(0, NB - 1);
         if ($urandom_range(0, 3) != 0 && op == 0) op = RD;
         issue(op, b, $urandom_range(0, (1 << ROW_W) - 1));
      end
      for (int b = 0; b < NB; b++)
         for (int s = 0; s < 8; s++)
            chk_reg(b, s, "R11");

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule